// File: doc/BRIEF.md
# Flagged Four-Bit Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a small datapath. It takes two operands of `WIDTH` bits (four by default) and a three-bit operation code, and returns a result of the same width with two status flags. The overflow flag reports signed two's-complement overflow. The zero flag reports an all-zero result.

The lower half of the code space (op bit 2 = 0) selects arithmetic. Increment, add, decrement and subtract all run through one ripple-carry adder. The adder is built from a chain of full-adder cells, and the second operand and the carry-in are steered by the operation code. The upper half (op bit 2 = 1) selects bitwise functions built from gate arrays. A final selector picks between the two halves.

Top module: `alu4_flag`

## Requirements
- R1: Code 3'b000 (increment) gives result = (A + 1) mod 2^WIDTH; the adder sees A, the constant 0001 and carry-in 0.
- R2: Code 3'b001 (add) gives result = (A + B) mod 2^WIDTH with carry-in 0.
- R3: Code 3'b010 (decrement) gives result = (A + 1111) mod 2^WIDTH, that is A minus one, with carry-in 0.
- R4: Code 3'b011 (subtract) gives result = (A + ~B + 1) mod 2^WIDTH, that is A minus B.
- R5: Code 3'b100 (NOT) gives result = ~A, and the value of B has no effect on any output.
- R6: Codes 3'b101, 3'b110 and 3'b111 give the bitwise A|B, A&B and A^B.
- R7: For codes 000 to 011, ovf_o is 1 exactly when the true signed result falls outside -2^(WIDTH-1) .. 2^(WIDTH-1)-1. This is the XOR of the carry into and out of the top bit.
- R8: For codes 100 to 111, ovf_o is 0.
- R9: zero_o is 1 exactly when every result bit is 0, for all eight codes.
- R10: The signed corners hold: 0111+0001 gives 1000, 1000+1111 gives 0111, 1000-0001 gives 0111, 1000 decremented gives 0111, and 0111 incremented gives 1000. Each of these sets ovf_o to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code; bit 2 selects the logic half |
| result_o | output | WIDTH | Selected result |
| ovf_o | output | 1 | Signed overflow of the arithmetic functions |
| zero_o | output | 1 | Result is all zeros |

## Verification
There is no state in this block. A fault in the operand steering or in the carry chain shows at the result and flag ports in the same evaluation as the input change. A broken carry link corrupts only the higher result bits and the overflow flag, and only for operand pairs that carry through that link. For that reason every code is driven with all operand pairs, and each is compared with a signed reference. A wrong half select or a missing overflow gate shows on the logic codes as a nonzero overflow or an adder value in place of the bitwise one.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int unsigned OP_W = 3;

  // low two code bits inside each half
  localparam logic [1:0] ARITH_INC = 2'b00;
  localparam logic [1:0] ARITH_ADD = 2'b01;
  localparam logic [1:0] ARITH_DEC = 2'b10;
  localparam logic [1:0] ARITH_SUB = 2'b11;

  localparam logic [1:0] LOGIC_NOT = 2'b00;
  localparam logic [1:0] LOGIC_OR  = 2'b01;
  localparam logic [1:0] LOGIC_AND = 2'b10;
  localparam logic [1:0] LOGIC_XOR = 2'b11;
endpackage

// File: rtl/alu4_full_adder.sv
module alu4_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (c_i & p);
endmodule

// File: rtl/alu4_ripple_adder.sv
module alu4_ripple_adder #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_o,
  output logic             cout_o
);
  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    alu4_full_adder u_fa (
      .a_i(a_i[g]),
      .b_i(b_i[g]),
      .c_i(carry[g]),
      .s_o(sum_o[g]),
      .c_o(carry[g+1])
    );
  end

  assign c_msb_o = carry[WIDTH-1];
  assign cout_o  = carry[WIDTH];

  // chain of cells must equal a wide add
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i}))
      a_r2_chain_sum: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
        else $error("ripple chain disagrees with wide add");
  end
endmodule

// File: rtl/alu4_operand_steer.sv
module alu4_operand_steer
  import alu4_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             cin_o
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ONES = '1;

  always_comb begin
    b_eff_o = b_i;
    cin_o   = 1'b0;
    unique case (sel_i)
      ARITH_INC: b_eff_o = ONE;
      ARITH_ADD: b_eff_o = b_i;
      ARITH_DEC: b_eff_o = ONES;
      ARITH_SUB: begin
        b_eff_o = ~b_i;
        cin_o   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu4_logic_unit.sv
module alu4_logic_unit
  import alu4_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    y_o = '0;
    unique case (sel_i)
      LOGIC_NOT: y_o = ~a_i;
      LOGIC_OR:  y_o = a_i | b_i;
      LOGIC_AND: y_o = a_i & b_i;
      LOGIC_XOR: y_o = a_i ^ b_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu4_flag.sv
module alu4_flag
  import alu4_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             ovf_o,
  output logic             zero_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic             is_logic;
  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] sum;
  logic             c_msb;
  logic             cout;
  logic [WIDTH-1:0] logic_y;

  assign is_logic = op_i[OP_W-1];

  alu4_operand_steer #(.WIDTH(WIDTH)) u_steer (
    .sel_i  (op_i[1:0]),
    .b_i    (b_i),
    .b_eff_o(b_eff),
    .cin_o  (cin)
  );

  alu4_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (cin),
    .sum_o  (sum),
    .c_msb_o(c_msb),
    .cout_o (cout)
  );

  alu4_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .sel_i(op_i[1:0]),
    .a_i  (a_i),
    .b_i  (b_i),
    .y_o  (logic_y)
  );

  assign result_o = is_logic ? logic_y : sum;
  assign ovf_o    = ~is_logic & (c_msb ^ cout);
  assign zero_o   = ~|result_o;

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      a_r8_no_overflow: assert (!(is_logic && ovf_o))
        else $error("overflow raised on a logic code");
      // overflow only when operand signs agree and result sign flips
      a_r7_overflow_sign: assert (!ovf_o ||
        ((a_i[MSB] == b_eff[MSB]) && (result_o[MSB] != a_i[MSB])))
        else $error("overflow without sign flip");
      a_r5_not_result: assert (!(op_i == 3'b100) || (result_o == ~a_i))
        else $error("NOT result wrong");
      a_r9_xor_zero: assert (!(op_i == 3'b111 && zero_o) || (a_i == b_i))
        else $error("zero after XOR of unequal operands");
    end
  end
endmodule

// File: tb/alu4_flag_tb.sv
module alu4_flag_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [2:0]   op;
  logic [W-1:0] res;
  logic         ovf, zf;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu4_flag #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(res), .ovf_o(ovf), .zero_o(zf)
  );

  function automatic void ref_model(input logic [2:0] o, input logic [W-1:0] x,
                                    input logic [W-1:0] y, output logic [W-1:0] r,
                                    output logic v);
    int sx, sy, t;
    sx = $signed(x); sy = $signed(y);
    v = 1'b0; t = 0;
    case (o)
      3'd0: t = sx + 1;
      3'd1: t = sx + sy;
      3'd2: t = sx - 1;
      3'd3: t = sx - sy;
      default: t = 0;
    endcase
    if (!o[2]) begin
      r = t[W-1:0];
      v = (t > 7) || (t < -8);
    end else begin
      case (o)
        3'd4: r = ~x;
        3'd5: r = x | y;
        3'd6: r = x & y;
        default: r = x ^ y;
      endcase
    end
  endfunction

  task automatic apply(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
  endtask

  task automatic check(input string tag, input logic [W+1:0] act, input logic [W+1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%b b=%b actual={res,ovf,zf}=%b expected=%b",
               tag, op, a, b, act, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [2:0] o, input logic [W-1:0] x,
                           input logic [W-1:0] y);
    logic [W-1:0] r; logic v;
    apply(o, x, y);
    ref_model(o, x, y, r, v);
    check(tag, {res, ovf, zf}, {r, v, (r == '0)});
  endtask

  // first vector: increment of zero
  task automatic test_initial;
    apply(3'b000, 4'd0, 4'd0);
    check("R1 initial inc", {res, ovf, zf}, {4'b0001, 1'b0, 1'b0});
  endtask

  task automatic test_examples;
    check_vec("R1 inc 5", 3'b000, 4'b0101, 4'b0000);
    check_vec("R2 add 3+2", 3'b001, 4'b0011, 4'b0010);
    check_vec("R3 dec 4", 3'b010, 4'b0100, 4'b1111);
    check_vec("R4 sub 6-2", 3'b011, 4'b0110, 4'b0010);
    check_vec("R6 and", 3'b110, 4'b1100, 4'b1010);
    check_vec("R6 xor", 3'b111, 4'b1100, 4'b1010);
    check_vec("R6 or", 3'b101, 4'b0001, 4'b0010);
  endtask

  task automatic test_corners;
    apply(3'b001, 4'b0111, 4'b0001);
    check("R10 7+1", {res, ovf, zf}, {4'b1000, 1'b1, 1'b0});
    apply(3'b001, 4'b1000, 4'b1111);
    check("R10 -8+-1", {res, ovf, zf}, {4'b0111, 1'b1, 1'b0});
    apply(3'b011, 4'b1000, 4'b0001);
    check("R10 -8-1", {res, ovf, zf}, {4'b0111, 1'b1, 1'b0});
    apply(3'b010, 4'b1000, 4'b0000);
    check("R10 dec -8", {res, ovf, zf}, {4'b0111, 1'b1, 1'b0});
    apply(3'b000, 4'b0111, 4'b0000);
    check("R10 inc 7", {res, ovf, zf}, {4'b1000, 1'b1, 1'b0});
    apply(3'b000, 4'b1111, 4'b0000);
    check("R9 R7 inc -1 to zero", {res, ovf, zf}, {4'b0000, 1'b0, 1'b1});
    apply(3'b011, 4'b0000, 4'b1000);
    check("R7 R4 0-(-8)", {res, ovf, zf}, {4'b1000, 1'b1, 1'b0});
  endtask

  task automatic test_not_ignores_b;
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        apply(3'b100, 4'(x), 4'(y));
        check("R5 not ignores b", {res, ovf, zf},
              {~4'(x), 1'b0, (4'(x) == 4'b1111)});
      end
    end
  endtask

  task automatic test_logic_no_ovf;
    for (int o = 4; o < 8; o++) begin
      apply(3'(o), 4'b0111, 4'b0001);
      n_checks++;
      if (ovf !== 1'b0) begin
        n_fail++;
        $display("FAIL R8 op=%0d actual ovf=%b expected 0", o, ovf);
      end
    end
  endtask

  task automatic test_exhaustive;
    for (int o = 0; o < 8; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          check_vec("R1 R2 R3 R4 R6 R7 R9 exhaustive", 3'(o), 4'(x), 4'(y));
  endtask

  initial begin
    op = 3'b000; a = '0; b = '0;
    test_initial();
    test_examples();
    test_corners();
    test_not_ignores_b();
    test_logic_no_ovf();
    test_exhaustive();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule